// File: doc/BRIEF.md
# Three-Level Chopper Duty and Mode Controller

This block drives a two-quadrant, three-level DC chopper that sits between an energy-storage coil and two series capacitors, and keeps both capacitor voltages at half the DC-link voltage. It receives the sampled upper and lower capacitor voltages, the half-link reference, a flag that says whether the converter is tied to the grid, and a request for the direction of energy flow. Each capacitor has its own regulator. Once per chopper period the block computes a new duty for each capacitor and holds it for the whole of the next period.

Before grid connection, each duty is simply the positive voltage shortfall of its capacitor, capped at one half. Only the normal charge pattern can result. After connection, a proportional-integral regulator with its own gains computes each duty. The duty is capped between zero and one, and the integrator saturates over the same range. The two held duties are converted to on-counts against a triangular carrier. Their sum decides between the normal pattern and the fast pattern. In the normal pattern the two capacitor intervals do not overlap and a shorted interval fills the gap. In the fast pattern both capacitors are served at once. The switch commands, the mode, the held duties and a period-start strobe all leave the block through registers, aligned with one another.

Top module: `chop_duty_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: The carrier is a triangle that rises from 0 to TCH and falls back, so one period lasts P = 2·TCH clocks. Its position runs from 0 to P−1. `prd_start` is high for exactly one cycle per period: the output cycle that shows position 0. The first such cycle follows the first edge after reset is released.
- R3: While `grid_on` is low at the last clock of a period, the following applies.
  - Each next duty is clamp(v_ref − v_cap, 0, 16384), where 16384 is one half in Q1.15.
  - Both integrators are cleared.
  - The mode is forced to normal charge, whatever `dir_dis` is.
- R4: While `grid_on` is high at the last clock of a period, the following applies.
  - Each next duty is clamp(((Kp·e) >>> 15) + I, 0, 32767), where e = v_ref − v_cap and I is the integrator before its update.
  - The default gains are Kp = Ki = 3277 for the upper capacitor, and Kp = 1311, Ki = 983 for the lower one. All gains are in Q1.15.
  - All values are signed Q1.15, and the right shifts are arithmetic (rounding toward minus infinity).
- R5: At that same period end, each integrator becomes clamp(I + ((Ki·e) >>> 15), 0, 32767). A regulator held at the upper limit therefore leaves it as soon as its error turns negative.
- R6: Duties, direction and mode are sampled only at the last clock of a period. Input changes at any other time have no effect until the next period starts.
- R7: On-counts are n = (d·P + 16384) >> 15. The fast bit is set when n_up + n_dn > P. `mode` is {discharge, fast}: 00 normal charge, 01 fast charge, 10 normal discharge, 11 fast discharge.
- R8: In charge modes, `gate_hi` is on for positions below n_up and `gate_lo` is on for positions at or above P − n_dn. In discharge modes both gates are the complement of those windows.
- R9: In a normal mode, the upper, lower and shorted intervals never overlap and add up to exactly P clocks. In a fast mode, the upper and lower intervals overlap and no shorted interval remains.
- R10: Each gate changes state at most twice in any window of one period that starts at a period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grid_on | input | 1 | Converter tied to the grid; enables the PI regulators |
| dir_dis | input | 1 | Direction request: 1 discharges the coil, 0 charges it |
| v_ref | input | 16 | Half-link reference voltage, signed Q1.15 |
| v_up | input | 16 | Upper capacitor voltage, signed Q1.15 |
| v_lo | input | 16 | Lower capacitor voltage, signed Q1.15 |
| gate_hi | output | 1 | Command for the switch that serves the upper capacitor |
| gate_lo | output | 1 | Command for the switch that serves the lower capacitor |
| mode | output | 2 | Active mode, {discharge, fast} |
| prd_start | output | 1 | High in the output cycle that shows carrier position 0 |
| duty_up | output | 16 | Held upper duty, Q1.15 |
| duty_dn | output | 16 | Held lower duty, Q1.15 |

## Verification
The fast modes are the hardest condition to reach from the ports. They appear only after the post-connection integrators have built up over many periods, until the two on-counts together exceed one period. Before connection they cannot appear at all. The stimulus therefore holds both capacitors well below the reference for dozens of periods after connection, until the upper integrator saturates. It then flips the direction request to reach fast discharge. Finally it drives the upper capacitor above the reference, so that the recovery from saturation is observed duty by duty.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int QF     = 15;
  localparam int Q_ONE  = 32767;
  localparam int Q_HALF = 16384;

  typedef enum logic [1:0] {
    MD_CHG      = 2'b00,
    MD_CHG_FAST = 2'b01,
    MD_DIS      = 2'b10,
    MD_DIS_FAST = 2'b11
  } chop_mode_e;

  function automatic logic signed [31:0] sat(input logic signed [31:0] x,
                                             input int lo, input int hi);
    if (x < lo) return 32'(lo);
    if (x > hi) return 32'(hi);
    return x;
  endfunction
endpackage

// File: rtl/chop_carrier.sv
module chop_carrier #(
  parameter int TCH = 16,
  parameter int CW  = $clog2(2*TCH+1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] pos,
  output logic          load
);
  localparam int P = 2*TCH;

  logic [CW-1:0] tri_q;
  logic          fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tri_q  <= '0;
      fall_q <= 1'b0;
    end else if (!fall_q) begin
      if (tri_q == CW'(TCH)) begin
        fall_q <= 1'b1;
        tri_q  <= tri_q - 1'b1;
      end else begin
        tri_q <= tri_q + 1'b1;
      end
    end else begin
      if (tri_q == CW'(1)) begin
        fall_q <= 1'b0;
        tri_q  <= '0;
      end else begin
        tri_q <= tri_q - 1'b1;
      end
    end
  end

  // position within the period: rising slope maps directly, falling slope mirrors
  assign pos  = fall_q ? (CW'(P) - tri_q) : tri_q;
  assign load = fall_q && (tri_q == CW'(1));

  a_r2_tri_bound: assert property (@(posedge clk) disable iff (rst)
    tri_q <= CW'(TCH));
  a_r2_peak_rising: assert property (@(posedge clk) disable iff (rst)
    (tri_q == CW'(TCH)) |-> !fall_q);
  a_r2_wrap_to_valley: assert property (@(posedge clk) disable iff (rst)
    load |=> (pos == '0));
endmodule

// File: rtl/chop_pi.sv
module chop_pi
  import chop_pkg::*;
#(
  parameter int KP = 3277,
  parameter int KI = 3277
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               grid,
  input  logic signed [15:0] v_ref,
  input  logic signed [15:0] v_cap,
  output logic signed [15:0] duty
);
  logic signed [31:0] err, prop, inc, sum_d, sum_i, duty_nx, integ_nx;
  logic signed [15:0] integ_q;

  always_comb begin
    err   = 32'(v_ref) - 32'(v_cap);
    prop  = (KP * err) >>> QF;
    inc   = (KI * err) >>> QF;
    sum_d = prop + 32'(integ_q);
    sum_i = inc + 32'(integ_q);
    if (grid) begin
      duty_nx  = sat(sum_d, 0, Q_ONE);
      integ_nx = sat(sum_i, 0, Q_ONE);
    end else begin
      duty_nx  = sat(err, 0, Q_HALF);
      integ_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      duty    <= '0;
    end else if (load) begin
      integ_q <= 16'(integ_nx);
      duty    <= 16'(duty_nx);
    end
  end

  a_r3_preconn_clear: assert property (@(posedge clk) disable iff (rst)
    (load && !grid) |=> (integ_q == 16'sd0 && duty <= 16'sd16384 && duty >= 16'sd0));
  a_r5_integ_nonneg: assert property (@(posedge clk) disable iff (rst)
    integ_q >= 16'sd0);
  a_r6_duty_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(duty));
endmodule

// File: rtl/chop_gate.sv
module chop_gate
  import chop_pkg::*;
#(
  parameter int TCH = 16,
  parameter int CW  = $clog2(2*TCH+1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CW-1:0]      pos,
  input  logic               grid,
  input  logic               dir_dis,
  input  logic signed [15:0] duty_a,
  input  logic signed [15:0] duty_b,
  output logic               gate_hi,
  output logic               gate_lo,
  output logic [1:0]         mode_o,
  output logic               prd_start,
  output logic signed [15:0] duty_a_o,
  output logic signed [15:0] duty_b_o
);
  localparam int P = 2*TCH;

  logic          dir_q;
  logic [31:0]   na_w, nb_w;
  logic [CW-1:0] na, nb;
  logic          fast, win_a, win_b;
  chop_mode_e    mode_c;

  always_ff @(posedge clk) begin
    if (rst)       dir_q <= 1'b0;
    else if (load) dir_q <= grid & dir_dis;
  end

  always_comb begin
    na_w   = ({16'd0, duty_a} * 32'(P) + 32'd16384) >> QF;
    nb_w   = ({16'd0, duty_b} * 32'(P) + 32'd16384) >> QF;
    na     = CW'(na_w);
    nb     = CW'(nb_w);
    fast   = ({1'b0, na} + {1'b0, nb}) > (CW+1)'(P);
    mode_c = chop_mode_e'({dir_q, fast});
    win_a  = pos < na;
    win_b  = pos >= (CW'(P) - nb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi   <= 1'b0;
      gate_lo   <= 1'b0;
      mode_o    <= 2'b00;
      prd_start <= 1'b0;
      duty_a_o  <= '0;
      duty_b_o  <= '0;
    end else begin
      gate_hi   <= dir_q ? !win_a : win_a;
      gate_lo   <= dir_q ? !win_b : win_b;
      mode_o    <= mode_c;
      prd_start <= (pos == '0);
      duty_a_o  <= duty_a;
      duty_b_o  <= duty_b;
    end
  end

  a_r3_dir_forced: assert property (@(posedge clk) disable iff (rst)
    (load && !grid) |=> !dir_q);
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !prd_start |-> $stable(mode_o));
  a_r9_chg_disjoint: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_CHG) |-> !(gate_hi && gate_lo));
  a_r9_dis_disjoint: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_DIS) |-> (gate_hi || gate_lo));
endmodule

// File: rtl/chop_duty_ctrl.sv
module chop_duty_ctrl
  import chop_pkg::*;
#(
  parameter int TCH   = 16,
  parameter int KP_HI = 3277,
  parameter int KI_HI = 3277,
  parameter int KP_LO = 1311,
  parameter int KI_LO = 983
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               grid_on,
  input  logic               dir_dis,
  input  logic signed [15:0] v_ref,
  input  logic signed [15:0] v_up,
  input  logic signed [15:0] v_lo,
  output logic               gate_hi,
  output logic               gate_lo,
  output logic [1:0]         mode,
  output logic               prd_start,
  output logic signed [15:0] duty_up,
  output logic signed [15:0] duty_dn
);
  localparam int CW = $clog2(2*TCH+1);
  localparam int NCAP = 2;
  localparam int KPS [NCAP] = '{KP_HI, KP_LO};
  localparam int KIS [NCAP] = '{KI_HI, KI_LO};

  logic [CW-1:0]      pos;
  logic               load;
  logic signed [15:0] vcap [NCAP];
  logic signed [15:0] duty [NCAP];

  assign vcap[0] = v_up;
  assign vcap[1] = v_lo;

  chop_carrier #(.TCH(TCH), .CW(CW)) u_car (
    .clk(clk), .rst(rst), .pos(pos), .load(load)
  );

  for (genvar g = 0; g < NCAP; g++) begin : g_reg
    chop_pi #(.KP(KPS[g]), .KI(KIS[g])) u_pi (
      .clk(clk), .rst(rst), .load(load), .grid(grid_on),
      .v_ref(v_ref), .v_cap(vcap[g]), .duty(duty[g])
    );
  end

  chop_gate #(.TCH(TCH), .CW(CW)) u_gate (
    .clk(clk), .rst(rst), .load(load), .pos(pos),
    .grid(grid_on), .dir_dis(dir_dis),
    .duty_a(duty[0]), .duty_b(duty[1]),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .mode_o(mode),
    .prd_start(prd_start), .duty_a_o(duty_up), .duty_b_o(duty_dn)
  );
endmodule

// File: tb/sim_chop_duty_ctrl.sv
`timescale 1ns/1ps
module sim_chop_duty_ctrl;
  localparam int TCH = 16;
  localparam int P   = 2*TCH;
  localparam int KP[2] = '{3277, 1311};
  localparam int KI[2] = '{3277, 983};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grid_on = 1'b0, dir_dis = 1'b0;
  logic signed [15:0] v_ref = 16'sd16384, v_up = 16'sd16384, v_lo = 16'sd16384;
  logic gate_hi, gate_lo, prd_start;
  logic [1:0] mode;
  logic signed [15:0] duty_up, duty_dn;

  always #2.5 clk = ~clk;

  chop_duty_ctrl u0 (
    .clk(clk), .rst(rst), .grid_on(grid_on), .dir_dis(dir_dis),
    .v_ref(v_ref), .v_up(v_up), .v_lo(v_lo),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .mode(mode),
    .prd_start(prd_start), .duty_up(duty_up), .duty_dn(duty_dn)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string duty_tag = "R1";

  function automatic int sat(int x, int lo, int hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: period position, held duties, integrators, direction
  int m_pos, m_dir;
  int m_duty[2], m_integ[2];
  int e_gh, e_gl, e_mode, e_ps, e_da, e_db;

  always @(posedge clk) begin
    int na, nb, fast, oa, ub, err, vc, d;
    if (rst) begin
      m_pos = 0; m_dir = 0;
      for (int k = 0; k < 2; k++) begin m_duty[k] = 0; m_integ[k] = 0; end
      e_gh = 0; e_gl = 0; e_mode = 0; e_ps = 0; e_da = 0; e_db = 0;
    end else begin
      na = (m_duty[0] * P + 16384) / 32768;
      nb = (m_duty[1] * P + 16384) / 32768;
      fast = (na + nb > P) ? 1 : 0;
      oa = (m_pos < na) ? 1 : 0;
      ub = (m_pos >= P - nb) ? 1 : 0;
      e_gh = m_dir ? 1 - oa : oa;
      e_gl = m_dir ? 1 - ub : ub;
      e_mode = m_dir * 2 + fast;
      e_ps = (m_pos == 0) ? 1 : 0;
      e_da = m_duty[0];
      e_db = m_duty[1];
      if (m_pos == P - 1) begin
        for (int k = 0; k < 2; k++) begin
          vc = (k == 0) ? int'(v_up) : int'(v_lo);
          err = int'(v_ref) - vc;
          if (grid_on) begin
            d = sat(((KP[k] * err) >>> 15) + m_integ[k], 0, 32767);
            m_integ[k] = sat(m_integ[k] + ((KI[k] * err) >>> 15), 0, 32767);
            m_duty[k] = d;
          end else begin
            m_duty[k] = sat(err, 0, 16384);
            m_integ[k] = 0;
          end
        end
        m_dir = (grid_on && dir_dis) ? 1 : 0;
      end
      m_pos = (m_pos + 1) % P;
    end
  end

  // per-period interval and transition bookkeeping taken from the outputs
  int c_o, c_u, c_b, c_z, t_h, t_l, w_mode, w_len;
  bit w_valid = 0;
  logic p_gh, p_gl;
  int fast_periods = 0;

  always @(negedge clk) begin
    int o_on, u_on;
    if (!done) begin
      chk(rst ? "R1" : "R8", "gate_hi", int'(gate_hi), e_gh);
      chk(rst ? "R1" : "R8", "gate_lo", int'(gate_lo), e_gl);
      chk(rst ? "R1" : "R7", "mode", int'(mode), e_mode);
      chk(rst ? "R1" : "R2", "prd_start", int'(prd_start), e_ps);
      chk(rst ? "R1" : duty_tag, "duty_up", int'(duty_up), e_da);
      chk(rst ? "R1" : duty_tag, "duty_dn", int'(duty_dn), e_db);
      if (rst) w_valid = 0;
      else begin
        if (prd_start) begin
          if (w_valid && w_len == P) begin
            if (w_mode[0] == 0) begin
              chk("R9", "normal overlap", c_b, 0);
              chk("R9", "normal interval sum", c_o + c_u + c_z, P);
            end else begin
              fast_periods++;
              chk("R9", "fast zero interval", c_z, 0);
            end
            chk("R10", "gate_hi transitions<=2", (t_h <= 2) ? 1 : 0, 1);
            chk("R10", "gate_lo transitions<=2", (t_l <= 2) ? 1 : 0, 1);
          end
          c_o = 0; c_u = 0; c_b = 0; c_z = 0; t_h = 0; t_l = 0; w_len = 0;
          w_mode = int'(mode);
          w_valid = 1;
        end
        if (w_valid) begin
          o_on = w_mode[1] ? int'(!gate_hi) : int'(gate_hi);
          u_on = w_mode[1] ? int'(!gate_lo) : int'(gate_lo);
          c_o += o_on; c_u += u_on;
          c_b += o_on & u_on;
          c_z += (!o_on && !u_on) ? 1 : 0;
          if (w_len > 0 || prd_start) begin
            if (gate_hi != p_gh) t_h++;
            if (gate_lo != p_gl) t_l++;
          end
          w_len++;
        end
        p_gh = gate_hi; p_gl = gate_lo;
      end
    end
  end

  task automatic periods(int n);
    repeat (n * P) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R3: below reference before connection, direction request must be ignored
    duty_tag = "R3";
    dir_dis = 1'b1;
    v_up = 16'sd8000; v_lo = 16'sd12000;
    periods(3);
    v_up = -16'sd5000; v_lo = 16'sd20000;   // clamp at one half and at zero
    periods(3);
    chk("R3", "preconn mode is normal charge", int'(mode), 0);
    // R4/R5: connected, sustained deficit builds the integrators into fast charge
    duty_tag = "R4";
    grid_on = 1'b1; dir_dis = 1'b0;
    v_up = 16'sd0; v_lo = 16'sd4000;
    periods(24);
    // R6: a short mid-period excursion must not reach the held duties
    duty_tag = "R6";
    repeat (7) @(negedge clk);
    v_up = 16'sd30000; grid_on = 1'b0;
    repeat (5) @(negedge clk);
    v_up = 16'sd0; grid_on = 1'b1;
    periods(2);
    // fast discharge
    duty_tag = "R7";
    dir_dis = 1'b1;
    periods(20);
    // R5: saturated regulator recovers once the error turns negative
    duty_tag = "R5";
    dir_dis = 1'b0;
    v_up = 16'sd20000;
    periods(12);
    chk("R7", "fast mode reached", (fast_periods > 0) ? 1 : 0, 1);
    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule